// File: doc/BRIEF.md
# Multiplexed Display Grid/Segment Scanner

This block scans a multiplexed vacuum-fluorescent display. It has 27 anode (segment) outputs and 3 grid outputs. A small register file holds one segment word per grid. A clock prescaler produces a tick. The sequencer spends one tick with every grid off and then several ticks with one grid on, showing that grid's word. After that it moves on to the next grid.

A static level input selects the duty. When it is high, only the first two grids are scanned (1/2 duty). When it is low, all three grids are scanned (1/3 duty). The grid outputs are active low so that an external pre-driver can invert them. The segment outputs are active high. A parallel write port updates the segment words. A word that is written is shown the next time its grid's slot begins.

Top module: `vfd_scan_driver`

## Requirements
- R1: While reset is asserted, and until the first slot begins, every grid output is high and every segment output is low.
- R2: One tick occurs every TICK_DIV clocks. A slot is one blank tick followed by SLOT_TICKS lit ticks, so a grid stays low for exactly TICK_DIV*SLOT_TICKS clocks.
- R3: With the latched duty select high, grids 0 and 1 alternate, and grid_n_o[2] stays high at all times.
- R4: With the latched duty select low, grids are lit in the order 0, 1, 2, then back to 0.
- R5: Grid outputs are active low, and at most one of them is low in any cycle. Grid k is driven on grid_n_o[k].
- R6: While grid k is lit, seg_o equals the word stored at address k, active high. During a blank tick seg_o is all zero.
- R7: Two different grids are never low in consecutive cycles. At least one all-blank period separates any two lit slots.
- R8: The duty select is sampled only when grid 0's slot begins, so a change never shortens or lengthens the frame that is in progress.
- R9: A write to address k does not alter a slot that is already lit. It appears when the next slot of grid k begins.
- R10: A write with wr_addr of GRID_N or more changes no stored word and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| duty_two_i | input | 1 | 1 = scan two grids (1/2 duty), 0 = scan three grids (1/3 duty) |
| wr_en_i | input | 1 | Write strobe for the segment store |
| wr_addr_i | input | 2 | Grid index of the word to write |
| wr_data_i | input | 27 | Segment word, bit i drives seg_o[i] |
| seg_o | output | 27 | Anode outputs, active high |
| grid_n_o | output | 3 | Grid outputs, active low |

## Verification
A wrong grid index, tick count or phase shows at the ports within one tick. The output then lights the wrong grid or lights it for the wrong number of clocks. A stale or corrupted stored word shows on seg_o in the first clock of the next slot for that grid. A duty latch that updates at the wrong time changes the grid order within one frame, at most 3*(1+SLOT_TICKS)*TICK_DIV clocks later. The reference model is compared on every clock, so each of these faults is reported in the cycle where it first appears.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  typedef enum logic {PH_BLANK = 1'b0, PH_LIT = 1'b1} phase_e;
endpackage

// File: rtl/vfd_tick_gen.sv
module vfd_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/vfd_seg_ram.sv
module vfd_seg_ram #(
  parameter int SEG_W  = 27,
  parameter int GRID_N = 3,
  parameter int AW     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [SEG_W-1:0] wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [SEG_W-1:0] rd_data_o
);
  logic [SEG_W-1:0] word_q [GRID_N];

  for (genvar g = 0; g < GRID_N; g++) begin : g_word
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q[g] <= '0;
      else if (hit) word_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int g = 0; g < GRID_N; g++)
      if (rd_addr_i == AW'(g)) rd_data_o = word_q[g];
  end
endmodule

// File: rtl/vfd_scan_seq.sv
module vfd_scan_seq
  import vfd_pkg::*;
#(
  parameter int SEG_W      = 27,
  parameter int GRID_N     = 3,
  parameter int SLOT_TICKS = 3,
  parameter int AW         = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              duty_two_i,
  input  logic [SEG_W-1:0]  rd_data_i,
  output logic [AW-1:0]     rd_addr_o,
  output logic [SEG_W-1:0]  seg_o,
  output logic [GRID_N-1:0] grid_n_o,
  output logic              duty_two_o
);
  localparam int TW = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(SLOT_TICKS - 1);
  localparam logic [AW-1:0] G_FULL = AW'(GRID_N - 1);

  phase_e             phase_q, phase_d;
  logic [TW-1:0]      tcnt_q, tcnt_d;
  logic [AW-1:0]      gidx_q, gidx_d, g_last;
  logic               dlat_q, dlat_d;
  logic [SEG_W-1:0]   seg_q, seg_d;
  logic [GRID_N-1:0]  grid_q, grid_d;

  assign g_last = dlat_q ? AW'(1) : G_FULL;

  always_comb begin
    phase_d = phase_q;
    tcnt_d  = tcnt_q;
    gidx_d  = gidx_q;
    dlat_d  = dlat_q;
    seg_d   = seg_q;
    grid_d  = grid_q;
    if (tick_i) begin
      if (phase_q == PH_BLANK) begin
        if (gidx_q == '0) dlat_d = duty_two_i;
        phase_d = PH_LIT;
        tcnt_d  = '0;
        seg_d   = rd_data_i;
        grid_d  = '1;
        grid_d[gidx_q] = 1'b0;
      end else if (tcnt_q == T_LAST) begin
        phase_d = PH_BLANK;
        seg_d   = '0;
        grid_d  = '1;
        gidx_d  = (gidx_q == g_last) ? '0 : gidx_q + AW'(1);
      end else begin
        tcnt_d  = tcnt_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_BLANK;
      tcnt_q  <= '0;
      gidx_q  <= '0;
      dlat_q  <= 1'b0;
      seg_q   <= '0;
      grid_q  <= '1;
    end else begin
      phase_q <= phase_d;
      tcnt_q  <= tcnt_d;
      gidx_q  <= gidx_d;
      dlat_q  <= dlat_d;
      seg_q   <= seg_d;
      grid_q  <= grid_d;
    end
  end

  assign rd_addr_o  = gidx_q;
  assign seg_o      = seg_q;
  assign grid_n_o   = grid_q;
  assign duty_two_o = dlat_q;
endmodule

// File: rtl/vfd_scan_driver.sv
module vfd_scan_driver #(
  parameter int SEG_W      = 27,
  parameter int GRID_N     = 3,
  parameter int TICK_DIV   = 4,
  parameter int SLOT_TICKS = 3,
  parameter int AW         = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              duty_two_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [SEG_W-1:0]  wr_data_i,
  output logic [SEG_W-1:0]  seg_o,
  output logic [GRID_N-1:0] grid_n_o
);
  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  logic             tick;
  logic [AW-1:0]    rd_addr;
  logic [SEG_W-1:0] rd_data;
  logic             duty_two_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  vfd_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(core_rst_n), .tick_o(tick)
  );

  vfd_seg_ram #(.SEG_W(SEG_W), .GRID_N(GRID_N), .AW(AW)) u_ram (
    .clk(clk), .rst_n(core_rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  vfd_scan_seq #(.SEG_W(SEG_W), .GRID_N(GRID_N), .SLOT_TICKS(SLOT_TICKS), .AW(AW)) u_seq (
    .clk(clk), .rst_n(core_rst_n), .tick_i(tick), .duty_two_i(duty_two_i),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr), .seg_o(seg_o),
    .grid_n_o(grid_n_o), .duty_two_o(duty_two_lat)
  );
endmodule

// File: rtl/vfd_scan_chk.sv
module vfd_scan_chk #(
  parameter int SEG_W  = 27,
  parameter int GRID_N = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SEG_W-1:0]  seg_o,
  input logic [GRID_N-1:0] grid_n_o,
  input logic              duty_two
);
  // R5: at most one grid driven low
  assert_one_grid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~grid_n_o));

  // R6: segments dark whenever no grid is lit
  assert_dark_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&grid_n_o) |-> (seg_o == '0));

  // R7: no direct switch from one lit grid to another
  assert_blank_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((~grid_n_o != '0) && ($past(~grid_n_o) != '0)) |-> (grid_n_o == $past(grid_n_o)));

  // R9: the word on the anodes does not move during a lit slot
  assert_seg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((~grid_n_o != '0) && (grid_n_o == $past(grid_n_o))) |-> $stable(seg_o));

  // R3: third grid stays off in two-grid mode
  assert_third_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    duty_two |-> grid_n_o[GRID_N-1]);
endmodule

bind vfd_scan_driver vfd_scan_chk #(.SEG_W(SEG_W), .GRID_N(GRID_N)) u_chk (
  .clk(clk), .rst_n(core_rst_n), .seg_o(seg_o), .grid_n_o(grid_n_o),
  .duty_two(duty_two_lat)
);

// File: tb/vfd_scan_driver_test.sv
`timescale 1ns/1ps
module vfd_scan_driver_test;
  localparam int SEG_W = 27, GRID_N = 3, TICK_DIV = 4, SLOT_TICKS = 3, AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic duty_two = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [SEG_W-1:0] wr_data = '0;
  logic [SEG_W-1:0] seg;
  logic [GRID_N-1:0] grid_n;

  always #2.5 clk = ~clk;

  vfd_scan_driver #(.SEG_W(SEG_W), .GRID_N(GRID_N), .TICK_DIV(TICK_DIV),
                    .SLOT_TICKS(SLOT_TICKS), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .duty_two_i(duty_two), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .seg_o(seg), .grid_n_o(grid_n)
  );

  int vectors = 0, fails = 0, cycles = 0;
  string tag = "R1";

  // behavioural reference
  int m_rel = 0, m_pc = 0, m_tc = 0, m_g = 0;
  bit m_lit = 0, m_dl = 0;
  logic [SEG_W-1:0] m_seg = '0;
  logic [GRID_N-1:0] m_gn = '1;
  logic [SEG_W-1:0] m_ram [GRID_N] = '{default: '0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rel = 0; m_pc = 0; m_tc = 0; m_g = 0; m_lit = 0; m_dl = 0;
      m_seg = '0; m_gn = '1;
      for (int i = 0; i < GRID_N; i++) m_ram[i] = '0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit tk;
      tk = (m_pc == TICK_DIV - 1);
      m_pc = tk ? 0 : m_pc + 1;
      if (tk) begin
        if (!m_lit) begin
          if (m_g == 0) m_dl = duty_two;
          m_lit = 1; m_tc = 0; m_seg = m_ram[m_g];
          m_gn = '1; m_gn[m_g] = 1'b0;
        end else if (m_tc == SLOT_TICKS - 1) begin
          m_lit = 0; m_seg = '0; m_gn = '1;
          m_g = (m_g == (m_dl ? 1 : GRID_N - 1)) ? 0 : m_g + 1;
        end else m_tc++;
      end
      if (wr_en && int'(wr_addr) < GRID_N) m_ram[wr_addr] = wr_data;
    end
  end

  // per-cycle comparison and run monitors
  int run0 = 0, runlen = -1, prev_g = -1;
  bit r3_seen_low = 0, r7_bad = 0, check_r3 = 0;
  int order_q[$];

  function automatic int lit_idx(logic [GRID_N-1:0] gn);
    for (int i = 0; i < GRID_N; i++) if (!gn[i]) return i;
    return -1;
  endfunction

  always @(negedge clk) begin
    int cur;
    cycles++;
    vectors++;
    if (seg !== m_seg || grid_n !== m_gn) begin
      fails++;
      $display("FAIL %s: seg=%h grid_n=%b expected seg=%h grid_n=%b at cycle %0d",
               tag, seg, grid_n, m_seg, m_gn, cycles);
    end
    cur = lit_idx(grid_n);
    if (!grid_n[0]) run0++;
    else if (run0 != 0) begin runlen = run0; run0 = 0; end
    if (cur >= 0 && prev_g >= 0 && cur != prev_g) r7_bad = 1;
    if (check_r3 && !grid_n[2]) r3_seen_low = 1;
    if (cur >= 0 && cur != prev_g) order_q.push_back(cur);
    prev_g = cur;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [SEG_W-1:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic chk(bit ok, string t, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  initial begin
    step(5);
    chk(grid_n === '1 && seg === '0, "R1", int'(grid_n), 7);
    rst_n = 1'b1;
    step(3);
    chk(grid_n === '1 && seg === '0, "R1", int'(seg), 0);
    tag = "R6";
    wr(0, 27'h0000ABC);
    wr(1, 27'h1234567);
    wr(2, 27'h7FFFFFF);
    tag = "R4";
    order_q.delete();
    step(200);
    chk(order_q.size() >= 6 && order_q[order_q.size()-3] + order_q[order_q.size()-2]
        + order_q[order_q.size()-1] == 3, "R4", order_q.size(), 6);
    chk(runlen == TICK_DIV * SLOT_TICKS, "R2", runlen, TICK_DIV * SLOT_TICKS);
    // write while lit: shown only at the next slot of that grid
    tag = "R9";
    while (grid_n[1] !== 1'b0) step(1);
    step(2);
    wr(1, 27'h2AAAAAA);
    step(100);
    tag = "R10";
    wr(3, 27'h5555555);
    step(100);
    // duty change in the middle of a frame
    tag = "R8";
    while (grid_n[1] !== 1'b0) step(1);
    duty_two = 1'b1;
    step(60);
    tag = "R3";
    check_r3 = 1;
    step(300);
    check_r3 = 0;
    chk(!r3_seen_low, "R3", int'(r3_seen_low), 0);
    tag = "R8";
    while (grid_n[1] !== 1'b0) step(1);
    duty_two = 1'b0;
    step(200);
    chk(!r7_bad, "R7", int'(r7_bad), 0);
    tag = "R5";
    wr(2, 27'h0F0F0F0);
    step(100);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule